// File: doc/BRIEF.md
# System Control and Reset Unit

This block sits on a simple register bus and handles three jobs. It keeps a chip configuration word that combines board straps with a byte of software boot flags. It keeps a register of peripheral reset lines. It also produces a delayed, fixed-width reset pulse for the CPU. The straps are captured while power-on reset is held low and do not change afterwards. The boot flag byte can be written only while the boot ROM overlay is enabled.

The first rising write of the soft-reset bit starts a countdown. When the countdown ends, the block pulses `cpu_rst`. The same write switches the boot ROM overlay off, and it stays off until the next power-on reset. From then on the flag byte is frozen. Each bit of the peripheral register drives its own reset line, and that line stays asserted for as long as the bit holds 1. Software resets a unit by writing its bit to 1 and then to 0.

The register bus is always ready, so there is no back-pressure. A write takes effect at the clock edge where `bus_sel` and `bus_wr` are both high. Read data is combinational from `bus_sel` and `bus_addr`. The bus carries no stream traffic, so it has no valid/ready pair.

Top module: `sysctl_rst_unit`

## Requirements
- R1: The peripheral reset register sits at word offset 2 and is N_PERIPH (22) bits wide. `periph_rst[i]` is 1 exactly while stored bit i is 1. Write data above bit N_PERIPH-1 is dropped, and a read returns the stored bits zero-extended.
- R2: The peripheral reset register changes only on a write to offset 2. Writes to other offsets and the CPU soft-reset sequence leave it untouched.
- R3: The configuration word is at offset 0. Its fields are: boot flags in [15:8]; the chip-variant strap in [16]; the boot-source strap in [18:17], with 0 or 1 meaning UART, 2 meaning SPI and 3 meaning I2C, reported as-is; and the dedicated pad level in [19]. All other bits read 0.
- R4: The strap fields are loaded from their inputs on every clock edge while `por_n` is low, and they hold after release. Writes never alter bits [7:0] or [31:16] of the configuration word.
- R5: The soft-reset register is bit 0 at offset 1 and reads back the last value written. A trigger occurs when a 1 is written while the stored bit is 0. This includes the first write of 1 after power-on, with no earlier write of 0.
- R6: `cpu_rst` rises SOFT_DELAY (16) clock edges after the edge that accepts a trigger. It stays high for exactly PULSE_CYC (4) cycles.
- R7: A trigger that arrives during the countdown or during the pulse is ignored. The stored bit still follows the write.
- R8: An accepted trigger clears `rom_overlay_en` from the next cycle onward, and only power-on reset sets it again. While it is clear, writes to the flag byte are ignored.
- R9: While `rom_overlay_en` is set, a write to offset 0 loads bits [15:8] into the flag byte.
- R10: While `por_n` is low, the peripheral register, the flag byte and the soft bit are cleared, `rom_overlay_en` is set and `cpu_rst` is low.
- R11: `bus_rdata` is 0 when `bus_sel` is low or when the offset is 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Synchronous power-on reset, active low |
| strap_variant | input | 1 | Chip-variant strap (reference clock select) |
| strap_boot_src | input | 2 | Second-stage boot source strap |
| strap_pad | input | 1 | Dedicated pad level |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write enable when selected |
| bus_addr | input | ADDR_W (2) | Word offset |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data |
| periph_rst | output | N_PERIPH (22) | Per-peripheral reset lines, active high |
| cpu_rst | output | 1 | CPU reset pulse |
| rom_overlay_en | output | 1 | Boot ROM overlay enable |

## Verification
Two things can coincide. The first is a fresh rising write of the soft bit landing while the countdown or the pulse is running. The second is peripheral register writes landing during that same window. The bench provokes both by toggling the soft bit 0, 1, 0, 1 throughout the countdown and into the final pulse cycle, while it rewrites peripheral patterns. A behavioural model compares `cpu_rst` against it on every clock: a correct design produces one pulse of the stated width, followed by a second pulse only after a trigger issued once the first pulse has ended. The peripheral lines must still follow every write unchanged.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  localparam int FLAG_LSB = 8;
  localparam int FLAG_W   = 8;
  localparam int STRAP_W  = 4;
  localparam int CFG_W    = FLAG_LSB + FLAG_W + STRAP_W;

  localparam int OFS_CFG  = 0;
  localparam int OFS_CPU  = 1;
  localparam int OFS_PRST = 2;

  // field order sets bit positions above the flag byte: variant, boot source, pad
  typedef struct packed {
    logic       pad;
    logic [1:0] boot_src;
    logic       variant;
  } strap_t;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_WAIT  = 2'd1,
    SEQ_PULSE = 2'd2
  } seq_state_t;
endpackage

// File: rtl/sysctl_cfg_word.sv
module sysctl_cfg_word
  import sysctl_pkg::*;
(
  input  logic              clk,
  input  logic              por_n,
  input  logic              strap_variant,
  input  logic [1:0]        strap_boot_src,
  input  logic              strap_pad,
  input  logic              flag_we,
  input  logic [FLAG_W-1:0] flag_wdata,
  input  logic              overlay_en,
  output logic [CFG_W-1:0]  cfg_bits
);
  strap_t            straps_q;
  logic [FLAG_W-1:0] flags_q;

  always_ff @(posedge clk) begin
    if (!por_n) begin
      straps_q.variant  <= strap_variant;
      straps_q.boot_src <= strap_boot_src;
      straps_q.pad      <= strap_pad;
      flags_q           <= '0;
    end else if (flag_we && overlay_en) begin
      flags_q <= flag_wdata;
    end
  end

  assign cfg_bits = {straps_q, flags_q, {FLAG_LSB{1'b0}}};
endmodule

// File: rtl/sysctl_periph_rst.sv
module sysctl_periph_rst #(
  parameter int N_PERIPH = 22
) (
  input  logic                clk,
  input  logic                por_n,
  input  logic                we,
  input  logic [N_PERIPH-1:0] wdata,
  output logic [N_PERIPH-1:0] rst_lines
);
  for (genvar i = 0; i < N_PERIPH; i++) begin : g_line
    logic bit_q;
    always_ff @(posedge clk) begin
      if (!por_n)  bit_q <= 1'b0;
      else if (we) bit_q <= wdata[i];
    end
    assign rst_lines[i] = bit_q;
  end
endmodule

// File: rtl/sysctl_cpu_seq.sv
module sysctl_cpu_seq
  import sysctl_pkg::*;
#(
  parameter int SOFT_DELAY = 16,
  parameter int PULSE_CYC  = 4
) (
  input  logic clk,
  input  logic por_n,
  input  logic soft_we,
  input  logic soft_wdata,
  output logic soft_q,
  output logic cpu_rst,
  output logic overlay_en
);
  localparam int LONGEST = (SOFT_DELAY > PULSE_CYC) ? SOFT_DELAY : PULSE_CYC;
  localparam int CW      = $clog2(LONGEST + 1);

  seq_state_t    st;
  logic [CW-1:0] cnt;
  logic          trigger;

  assign trigger = soft_we && soft_wdata && !soft_q;

  always_ff @(posedge clk) begin
    if (!por_n) begin
      st         <= SEQ_IDLE;
      cnt        <= '0;
      soft_q     <= 1'b0;
      overlay_en <= 1'b1;
    end else begin
      if (soft_we) soft_q <= soft_wdata;
      unique case (st)
        SEQ_IDLE: if (trigger) begin
          st         <= SEQ_WAIT;
          cnt        <= CW'(SOFT_DELAY - 1);
          overlay_en <= 1'b0;
        end
        SEQ_WAIT: if (cnt == '0) begin
          st  <= SEQ_PULSE;
          cnt <= CW'(PULSE_CYC - 1);
        end else begin
          cnt <= cnt - 1'b1;
        end
        SEQ_PULSE: if (cnt == '0) st <= SEQ_IDLE;
                   else           cnt <= cnt - 1'b1;
        default: st <= SEQ_IDLE;
      endcase
    end
  end

  assign cpu_rst = (st == SEQ_PULSE);
endmodule

// File: rtl/sysctl_rst_unit.sv
module sysctl_rst_unit
  import sysctl_pkg::*;
#(
  parameter int ADDR_W     = 2,
  parameter int DATA_W     = 32,
  parameter int N_PERIPH   = 22,
  parameter int SOFT_DELAY = 16,
  parameter int PULSE_CYC  = 4
) (
  input  logic                clk,
  input  logic                por_n,
  input  logic                strap_variant,
  input  logic [1:0]          strap_boot_src,
  input  logic                strap_pad,
  input  logic                bus_sel,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  output logic [N_PERIPH-1:0] periph_rst,
  output logic                cpu_rst,
  output logic                rom_overlay_en
);
  logic             hit_cfg, hit_cpu, hit_prst, wr_en;
  logic [CFG_W-1:0] cfg_bits;
  logic [DATA_W-1:0] cfg_word;
  logic             soft_q;
  logic             unused_wdata;

  assign wr_en    = bus_sel && bus_wr;
  assign hit_cfg  = (bus_addr == ADDR_W'(OFS_CFG));
  assign hit_cpu  = (bus_addr == ADDR_W'(OFS_CPU));
  assign hit_prst = (bus_addr == ADDR_W'(OFS_PRST));
  assign unused_wdata = ^bus_wdata;

  sysctl_cfg_word u_cfg (
    .clk            (clk),
    .por_n          (por_n),
    .strap_variant  (strap_variant),
    .strap_boot_src (strap_boot_src),
    .strap_pad      (strap_pad),
    .flag_we        (wr_en && hit_cfg),
    .flag_wdata     (bus_wdata[FLAG_LSB +: FLAG_W]),
    .overlay_en     (rom_overlay_en),
    .cfg_bits       (cfg_bits)
  );

  sysctl_periph_rst #(.N_PERIPH(N_PERIPH)) u_prst (
    .clk       (clk),
    .por_n     (por_n),
    .we        (wr_en && hit_prst),
    .wdata     (bus_wdata[N_PERIPH-1:0]),
    .rst_lines (periph_rst)
  );

  sysctl_cpu_seq #(.SOFT_DELAY(SOFT_DELAY), .PULSE_CYC(PULSE_CYC)) u_seq (
    .clk        (clk),
    .por_n      (por_n),
    .soft_we    (wr_en && hit_cpu),
    .soft_wdata (bus_wdata[0]),
    .soft_q     (soft_q),
    .cpu_rst    (cpu_rst),
    .overlay_en (rom_overlay_en)
  );

  assign cfg_word = DATA_W'(cfg_bits);

  always_comb begin
    bus_rdata = '0;
    if (bus_sel) begin
      if (hit_cfg)       bus_rdata = cfg_word;
      else if (hit_cpu)  bus_rdata = DATA_W'(soft_q);
      else if (hit_prst) bus_rdata = DATA_W'(periph_rst);
    end
  end
endmodule

// File: rtl/sysctl_rst_unit_chk.sv
module sysctl_rst_unit_chk #(
  parameter int ADDR_W    = 2,
  parameter int DATA_W    = 32,
  parameter int N_PERIPH  = 22,
  parameter int PULSE_CYC = 4
) (
  input logic                clk,
  input logic                por_n,
  input logic                bus_sel,
  input logic                bus_wr,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic [DATA_W-1:0]   cfg_word,
  input logic [N_PERIPH-1:0] periph_rst,
  input logic                cpu_rst,
  input logic                rom_overlay_en
);
  int hi_cnt;
  always_ff @(posedge clk) begin
    if (!por_n)       hi_cnt <= 0;
    else if (cpu_rst) hi_cnt <= hi_cnt + 1;
    else              hi_cnt <= 0;
  end

  a_r2_prst_only_by_write: assert property (@(posedge clk) disable iff (!por_n)
    !$past(bus_sel && bus_wr && bus_addr == ADDR_W'(2)) |-> $stable(periph_rst));

  a_r4_straps_hold: assert property (@(posedge clk) disable iff (!por_n)
    $past(por_n) |-> $stable(cfg_word[19:16]));

  a_r6_pulse_not_long: assert property (@(posedge clk) disable iff (!por_n)
    cpu_rst |-> hi_cnt < PULSE_CYC);

  a_r6_pulse_full: assert property (@(posedge clk) disable iff (!por_n)
    $fell(cpu_rst) |-> hi_cnt == PULSE_CYC);

  a_r8_overlay_sticky: assert property (@(posedge clk) disable iff (!por_n)
    !$past(rom_overlay_en) |-> !rom_overlay_en);

  a_r8_flags_frozen: assert property (@(posedge clk) disable iff (!por_n)
    !$past(rom_overlay_en) |-> $stable(cfg_word[15:8]));
endmodule

bind sysctl_rst_unit sysctl_rst_unit_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_PERIPH(N_PERIPH), .PULSE_CYC(PULSE_CYC)
) u_chk (.*);

// File: tb/sysctl_rst_unit_test.sv
`timescale 1ns/1ps
module sysctl_rst_unit_test;
  localparam int DLY = 16;
  localparam int PW  = 4;
  localparam int NP  = 22;

  logic        clk = 1'b0;
  logic        por_n = 1'b0;
  logic        strap_variant = 1'b1;
  logic [1:0]  strap_boot_src = 2'd2;
  logic        strap_pad = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NP-1:0] periph_rst;
  logic        cpu_rst;
  logic        rom_overlay_en;

  int n_chk = 0;
  int n_bad = 0;
  bit started = 0;

  always #2.5 clk = ~clk;

  sysctl_rst_unit #(.SOFT_DELAY(DLY), .PULSE_CYC(PW), .N_PERIPH(NP)) uut (
    .clk(clk), .por_n(por_n), .strap_variant(strap_variant),
    .strap_boot_src(strap_boot_src), .strap_pad(strap_pad),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .periph_rst(periph_rst),
    .cpu_rst(cpu_rst), .rom_overlay_en(rom_overlay_en)
  );

  // behavioural reference model
  int          m_since = -1;
  bit          m_ovl = 1;
  bit [7:0]    m_flags = 0;
  bit          m_soft = 0;
  bit [NP-1:0] m_prst = 0;
  bit          m_var = 0, m_pad = 0;
  bit [1:0]    m_src = 0;
  bit          m_busy, m_wr;

  always @(posedge clk) begin
    started = 1;
    if (!por_n) begin
      m_since = -1; m_ovl = 1; m_flags = 0; m_soft = 0; m_prst = 0;
      m_var = strap_variant; m_src = strap_boot_src; m_pad = strap_pad;
    end else begin
      m_wr   = bus_sel && bus_wr;
      m_busy = (m_since >= 0);
      if (m_busy) begin
        m_since = m_since + 1;
        if (m_since == DLY + PW) m_since = -1;
      end
      if (m_wr && bus_addr == 2'd0 && m_ovl) m_flags = bus_wdata[15:8];
      if (m_wr && bus_addr == 2'd2) m_prst = bus_wdata[NP-1:0];
      if (m_wr && bus_addr == 2'd1) begin
        if (bus_wdata[0] && !m_soft && !m_busy) begin
          m_since = 0;
          m_ovl = 0;
        end
        m_soft = bus_wdata[0];
      end
    end
  end

  function automatic logic [31:0] exp_rdata();
    if (!bus_sel) return 32'd0;
    case (bus_addr)
      2'd0: return {12'd0, m_pad, m_src, m_var, m_flags, 8'd0};
      2'd1: return {31'd0, m_soft};
      2'd2: return 32'(m_prst);
      default: return 32'd0;
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (started) begin
      chk("R1 R2 R10 periph_rst", 32'(periph_rst), 32'(m_prst));
      chk("R6 R7 R10 cpu_rst", 32'(cpu_rst),
          32'((m_since >= DLY) && (m_since < DLY + PW)));
      chk("R8 R10 rom_overlay_en", 32'(rom_overlay_en), 32'(m_ovl));
      chk("R3 R4 R5 R9 R11 bus_rdata", bus_rdata, exp_rdata());
    end
  end

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(posedge clk); #1;
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 0; bus_wdata = 32'hDEAD_BEEF;
  endtask

  task automatic look(logic [1:0] a, int n);
    @(posedge clk); #1;
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    repeat (n) @(posedge clk);
  endtask

  task automatic por(int n);
    @(posedge clk); #1; por_n = 0;
    repeat (n) @(posedge clk);
    #1; por_n = 1;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #1; por_n = 1;
    // R11: deselected read returns zero
    look(2'd0, 2);
    bus_sel = 0; @(posedge clk); #1;
    // R3: hand-computed strap readout variant=1 src=2 pad=0
    bus_sel = 1; bus_addr = 2'd0; #1;
    chk("R3 cfg after POR", bus_rdata, 32'h0005_0000);
    // R4 R9: full write only changes flag byte
    wr(2'd0, 32'hFFFF_FFFF);
    look(2'd0, 2);
    chk("R9 flags written", bus_rdata, 32'h0005_FF00);
    // R4: straps move after release, word holds
    strap_variant = 0; strap_boot_src = 2'd3; strap_pad = 1;
    look(2'd0, 3);
    // R1: peripheral patterns, high bits dropped
    wr(2'd2, 32'hFFFF_FFFF); look(2'd2, 2);
    chk("R1 all lines", 32'(periph_rst), 32'h003F_FFFF);
    wr(2'd2, 32'h0000_0005); look(2'd2, 2);
    wr(2'd3, 32'h1234_5678); look(2'd3, 2);   // R11 unmapped
    wr(2'd2, 32'h0020_0400); look(2'd2, 1);
    // R5 R6: direct 1 triggers; R7 toggles during pending and pulse
    wr(2'd1, 32'h1);
    look(2'd1, 3);
    wr(2'd1, 32'h0); wr(2'd1, 32'h1);
    wr(2'd2, 32'h0000_0001);
    for (int i = 0; i < 6; i++) begin
      wr(2'd1, 32'h0); wr(2'd1, 32'h1);
    end
    look(2'd0, 4);
    // R8: flags frozen
    wr(2'd0, 32'h0000_3C00); look(2'd0, 2);
    chk("R8 flags locked", bus_rdata[15:8], 32'hFF);
    // R5: second trigger after pulse ends
    wr(2'd1, 32'h0); wr(2'd1, 32'h1);
    look(2'd1, DLY + PW + 4);
    // R10: power-on reset with new straps
    wr(2'd2, 32'h0001_1111);
    por(3);
    look(2'd0, 2);
    chk("R10 R3 cfg after second POR", bus_rdata, 32'h000E_0000);
    chk("R10 overlay back", 32'(rom_overlay_en), 32'd1);
    wr(2'd0, 32'h0000_A500); look(2'd0, 2);
    chk("R9 flags writable again", bus_rdata, 32'h000E_A500);
    look(2'd1, 2);
    bus_sel = 0; @(posedge clk); @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule